// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer, written as a digital model. The oscillator signal reaches it as a clock-enabled pulse stream: each clock cycle with `in_pulse` high stands for one oscillator edge. A prescaler that divides by 10 or 11 feeds a 9-bit main counter. A 4-bit swallow counter drives the modulus select. In each output period the prescaler runs at 11 for the first A prescaler cycles and at 10 for the rest. This gives a total ratio of 10×(M+1)+A.

When the bypass bit is set, the prescaler and the swallow counter play no part, and the main counter counts input pulses directly, dividing by M+1. The divide settings are captured only when a new output period begins: at synchronous reset, and on the input pulse that ends a period. A period therefore always runs with one consistent setting. Each completed period produces a one-cycle `fp` strobe.

Top module: `fbdiv_feedback_divider`

## Requirements
- R1: With bypass low, the number of input pulses in each output period is 10×(M+1)+A, for M in 1..511 and A in 0..15 with A ≤ M+1.
- R2: With bypass high, the number of input pulses in each output period is M+1.
- R3: `fp` is high for exactly one clock, in the cycle after the edge that accepts the last input pulse of a period. It is never high in two consecutive cycles.
- R4: `mod_sel` (1 = divide by 11, 0 = divide by 10) is high while fewer than 11×A input pulses of the current period have been accepted, and low after that. It is always low in a period that runs in bypass.
- R5: M, A and bypass are sampled only at reset and on the pulse that ends a period. Changes to these inputs at any other time do not affect the period in progress.
- R6: A cycle with `in_pulse` low advances no state: the next cycle has `fp` low and `mod_sel` unchanged.
- R7: A synchronous reset clears `fp`, restarts the period with zero pulses counted, and captures the current M, A and bypass. `mod_sel` then reads 1 exactly when A ≠ 0 and bypass is low.
- R8: The extreme settings divide as stated: M=1, A=0 gives 20; M=1, A=2 gives 22; M=511, A=15 gives 5135; M=1 in bypass gives 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_pulse | input | 1 | One oscillator input pulse when high |
| m_val | input | 9 | Main counter setting M (1..511) |
| a_val | input | 4 | Swallow count A (0..15, A ≤ M+1) |
| bypass | input | 1 | 1 = prescaler bypassed, divide by M+1 |
| fp | output | 1 | One-cycle strobe per completed output period |
| mod_sel | output | 1 | Prescaler modulus select, 1 = divide by 11 |

## Verification
The bench targets the boundary A = M+1, where every prescaler cycle divides by 11. An off-by-one in the swallow counter there would add or drop one pulse per period. It also runs the largest ratio, 5135, where a truncated main-counter width would wrap early, and bypass with M=1, where a design that still counted through the prescaler would stretch the period tenfold.

While the first half of a period is in progress, the bench drives other settings onto the inputs. A design that sampled those inputs continuously would produce periods of mixed length. It also inserts long stretches with no input pulses and a reset in the middle of a period. A divider that counted clocks instead of pulses, or that kept a stale partial count after reset, would put `fp` in the wrong cycle.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

   // Prescaler operating mode for the current prescaler cycle
   typedef enum logic [1:0] {
      MODE_DIRECT = 2'd0,   // every input pulse ends a prescaler cycle
      MODE_LOW    = 2'd1,   // divide by the low modulus
      MODE_HIGH   = 2'd2    // divide by the low modulus plus one
   } pre_mode_e;

   localparam int DEF_M_W     = 9;
   localparam int DEF_A_W     = 4;
   localparam int DEF_PRE_LOW = 10;

endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
   import fbdiv_pkg::*;
#(
   parameter int PRE_LOW = DEF_PRE_LOW
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      pulse,
   input  pre_mode_e mode,
   output logic      tc
);

   localparam int PRE_W = $clog2(PRE_LOW + 1);

   logic [PRE_W-1:0] cnt;
   logic [PRE_W-1:0] limit;

   always_comb begin
      case (mode)
         MODE_HIGH: limit = PRE_W'(PRE_LOW);
         MODE_LOW:  limit = PRE_W'(PRE_LOW - 1);
         default:   limit = '0;
      endcase
   end

   assign tc = pulse && ((mode == MODE_DIRECT) || (cnt == limit));

   always_ff @(posedge clk) begin
      if (rst || tc)
         cnt <= '0;
      else if (pulse)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
   parameter int A_W = 4
) (
   input  logic           clk,
   input  logic           load,
   input  logic [A_W-1:0] load_val,
   input  logic           step,
   output logic           active
);

   logic [A_W-1:0] remain;

   assign active = (remain != '0);

   always_ff @(posedge clk) begin
      if (load)
         remain <= load_val;
      else if (step && active)
         remain <= remain - 1'b1;
   end

endmodule

// File: rtl/fbdiv_main_ctr.sv
module fbdiv_main_ctr #(
   parameter int M_W = 9
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           step,
   input  logic [M_W-1:0] limit,
   output logic           last
);

   logic [M_W-1:0] cnt;

   assign last = step && (cnt == limit);

   always_ff @(posedge clk) begin
      if (rst || last)
         cnt <= '0;
      else if (step)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/fbdiv_feedback_divider.sv
module fbdiv_feedback_divider
   import fbdiv_pkg::*;
#(
   parameter int M_W     = DEF_M_W,
   parameter int A_W     = DEF_A_W,
   parameter int PRE_LOW = DEF_PRE_LOW
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_pulse,
   input  logic [M_W-1:0] m_val,
   input  logic [A_W-1:0] a_val,
   input  logic           bypass,
   output logic           fp,
   output logic           mod_sel
);

   generate
      if (M_W < 1) begin : g_bad_m_w
         $error("fbdiv_feedback_divider: M_W must be at least 1");
      end
      if (A_W < 1) begin : g_bad_a_w
         $error("fbdiv_feedback_divider: A_W must be at least 1");
      end
      if (PRE_LOW < 2) begin : g_bad_pre
         $error("fbdiv_feedback_divider: PRE_LOW must be at least 2");
      end
   endgenerate

   logic           pre_tc;
   logic           sw_active;
   logic           period_end;
   logic           restart;
   logic [M_W-1:0] m_q;
   logic           byp_q;
   pre_mode_e      mode;

   assign restart = rst || period_end;

   // Settings are held for a whole period
   always_ff @(posedge clk) begin
      if (restart) begin
         m_q   <= m_val;
         byp_q <= bypass;
      end
   end

   always_comb begin
      if (byp_q)
         mode = MODE_DIRECT;
      else if (sw_active)
         mode = MODE_HIGH;
      else
         mode = MODE_LOW;
   end

   fbdiv_prescaler #(.PRE_LOW(PRE_LOW)) u_pre (
      .clk   (clk),
      .rst   (rst),
      .pulse (in_pulse),
      .mode  (mode),
      .tc    (pre_tc)
   );

   fbdiv_swallow #(.A_W(A_W)) u_swallow (
      .clk      (clk),
      .load     (restart),
      .load_val (a_val),
      .step     (pre_tc),
      .active   (sw_active)
   );

   fbdiv_main_ctr #(.M_W(M_W)) u_main (
      .clk   (clk),
      .rst   (rst),
      .step  (pre_tc),
      .limit (m_q),
      .last  (period_end)
   );

   always_ff @(posedge clk) begin
      if (rst)
         fp <= 1'b0;
      else
         fp <= period_end;
   end

   assign mod_sel = !byp_q && sw_active;

endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker (
   input logic clk,
   input logic rst,
   input logic in_pulse,
   input logic fp,
   input logic mod_sel
);

   // R3: the strobe never lasts two cycles
   assert_fp_single_R3: assert property (@(posedge clk) disable iff (rst)
      fp |=> !fp);

   // R1: a strobe only follows an accepted input pulse
   assert_fp_after_pulse_R1: assert property (@(posedge clk) disable iff (rst)
      fp |-> $past(in_pulse));

   // R6: an idle cycle moves nothing
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!in_pulse) |=> (!fp && $stable(mod_sel)));

   // R4: the modulus select only drops on an input pulse
   assert_mod_fall_R4: assert property (@(posedge clk) disable iff (rst)
      ($fell(mod_sel) && !$past(rst)) |-> $past(in_pulse));

   // R7: reset leaves the strobe low
   assert_reset_clear_R7: assert property (@(posedge clk)
      rst |=> !fp);

endmodule

bind fbdiv_feedback_divider fbdiv_checker u_fbdiv_checker (
   .clk      (clk),
   .rst      (rst),
   .in_pulse (in_pulse),
   .fp       (fp),
   .mod_sel  (mod_sel)
);

// File: tb/tb_fbdiv_feedback_divider.sv
module tb_fbdiv_feedback_divider;

   logic       clk = 1'b0;
   logic       rst;
   logic       in_pulse;
   logic [8:0] m_val;
   logic [3:0] a_val;
   logic       bypass;
   logic       fp;
   logic       mod_sel;

   always #10 clk = ~clk;   // 50 MHz

   fbdiv_feedback_divider dut (
      .clk      (clk),
      .rst      (rst),
      .in_pulse (in_pulse),
      .m_val    (m_val),
      .a_val    (a_val),
      .bypass   (bypass),
      .fp       (fp),
      .mod_sel  (mod_sel)
   );

   int n_chk  = 0;
   int n_fail = 0;

   // Reference model state
   int    cnt;          // pulses accepted in the current period
   int    cm, ca;       // settings of the current period
   bit    cb;
   bit    exp_fp;
   bit    exp_mod;
   bit    prev_fp;
   bit    garbage;      // other settings were driven this period
   string fp_tag;
   int    periods;

   function automatic int ratio(int m, int a, bit b);
      return b ? (m + 1) : (10 * (m + 1) + a);
   endfunction

   function automatic bit extreme(int m, int a, bit b);
      return (m == 1) || (m == 511 && a == 15 && !b);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: compare at the negedge, drive, model the next posedge
   task automatic cyc(input bit p, input bit r, input int m, input int a, input bit b);
      chk(fp === exp_fp, fp_tag, int'(fp), int'(exp_fp));
      chk(mod_sel === exp_mod, r ? "R7" : "R4", int'(mod_sel), int'(exp_mod));
      chk(!(fp && prev_fp), "R3", int'(fp && prev_fp), 0);
      prev_fp = fp;

      rst      = r;
      in_pulse = p;
      m_val    = 9'(m);
      a_val    = 4'(a);
      bypass   = b;

      if (r) begin
         cnt = 0; cm = m; ca = a; cb = b; exp_fp = 0; garbage = 0;
         fp_tag = "R7";
      end else if (!p) begin
         exp_fp = 0;
         fp_tag = "R6";
      end else begin
         cnt++;
         if (cnt == ratio(cm, ca, cb)) begin
            exp_fp = 1;
            if (garbage)              fp_tag = "R5";
            else if (extreme(cm, ca, cb)) fp_tag = "R8";
            else if (cb)              fp_tag = "R2";
            else                      fp_tag = "R1";
            cnt = 0; cm = m; ca = a; cb = b; garbage = 0;
            periods++;
         end else begin
            exp_fp = 0;
            fp_tag = cb ? "R2" : "R1";
         end
      end
      exp_mod = !cb && (cnt < 11 * ca);
      @(negedge clk);
   endtask

   task automatic run_cfg(input int m, input int a, input bit b, input int nper, input int density);
      int target;
      target = periods + nper + 1;
      while (periods < target) begin
         bit p;
         p = ($urandom % 100) < density;
         if (cnt > 0 && cnt < ratio(cm, ca, cb) / 2 && ($urandom % 4) == 0) begin
            int gm, ga;
            gm = 1 + ($urandom % 511);
            ga = $urandom % 16;
            if (ga > gm + 1) ga = gm + 1;
            garbage = 1;
            cyc(p, 0, gm, ga, $urandom % 2);
         end else begin
            cyc(p, 0, m, a, b);
         end
      end
   endtask

   task automatic idle(input int n, input int m, input int a, input bit b);
      for (int i = 0; i < n; i++) cyc(0, 0, m, a, b);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst = 1; in_pulse = 0; m_val = 9'd1; a_val = 4'd0; bypass = 0;
      cnt = 0; cm = 1; ca = 0; cb = 0; exp_fp = 0; prev_fp = 0;
      garbage = 0; periods = 0; fp_tag = "R7";
      @(negedge clk);
      // R7: reset state with A=0 and with A=3
      chk(fp === 1'b0, "R7", int'(fp), 0);
      chk(mod_sel === 1'b0, "R7", int'(mod_sel), 0);
      cyc(0, 1, 5, 3, 0);
      chk(mod_sel === 1'b1, "R7", int'(mod_sel), 1);
      cyc(0, 1, 1, 0, 0);

      run_cfg(1, 0, 0, 3, 80);        // R8 ratio 20
      run_cfg(1, 2, 0, 2, 80);        // R8 A = M+1
      run_cfg(4, 5, 0, 2, 50);        // R1 A = M+1
      run_cfg(37, 9, 0, 2, 100);      // R1 back-to-back pulses
      run_cfg(511, 15, 0, 1, 95);     // R8 ratio 5135
      run_cfg(511, 0, 1, 2, 70);      // R2
      run_cfg(1, 0, 1, 3, 60);        // R8 bypass ratio 2
      run_cfg(20, 7, 1, 2, 70);       // R2 with A ignored

      // R6: long idle stretch inside a period
      run_cfg(12, 4, 0, 1, 70);
      for (int i = 0; i < 30; i++) cyc(1, 0, 12, 4, 0);
      idle(40, 12, 4, 0);
      run_cfg(12, 4, 0, 1, 70);

      // R7: reset in mid-period
      for (int i = 0; i < 25; i++) cyc(1, 0, 300, 8, 0);
      cyc(0, 1, 7, 3, 0);
      run_cfg(7, 3, 0, 2, 70);

      for (int k = 0; k < 6; k++) begin
         int m, a;
         m = 1 + ($urandom % 511);
         a = $urandom % 16;
         if (a > m + 1) a = m + 1;
         run_cfg(m, a, ($urandom % 5) == 0, 1, 75);  // R1 / R2 random settings
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule